// File: doc/BRIEF.md
# Flash Command Register Controller

This block is the device-side command interface of a byte-wide flash memory that is erased as a whole and programmed one byte at a time. It is a synthesizable model. Bus write cycles arrive on a chip-enable / write-strobe pair, and the block decodes them into operating modes: array read, identifier read, erase setup and start, erase verify, program setup and start, program verify, and a two-write reset. A small internal byte array, whose size is a parameter, holds the contents. A program operation can only clear bits. An erase sets every byte to FFh.

Command access depends on a high-voltage enable input. While that input is low, the block behaves as a read-only memory. While it is high, erase and program run for parameterized cycle counts, and a busy flag is high during that time. The count doubles as the stop timer. An operation that no verify interrupts ends by itself, and the block then waits for a verify or a reset. All pins are plain level signals sampled on the clock. There is no streaming interface, so back-pressure does not apply.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, or while `hv_en` is low, the block is in array-read mode and ignores writes. The array resets to all FFh and `busy` is low.
- R2: While `cs_n` and `rd_n` are both low, `q_oe` is high and `q` shows the mode's read value one clock later. `q_oe` is low otherwise. In array-read mode the read value is the byte at `addr`.
- R3: The address of a write is captured on the falling edge of `wr_n` with `cs_n` low. The data and the command act on the rising edge. An address change between the two edges has no effect.
- R4: After command 90h, a read at address 0 returns 20h, a read at address 1 returns 07h, and a read at any other address returns 00h.
- R5: After command 40h, the next write supplies the address and the data. `busy` is then high for `PROG_CYC` cycles, and at the end the byte becomes old AND data.
- R6: Command C0h makes reads return the byte at the last program address. A C0h written while programming is still running stops it and leaves the byte unchanged.
- R7: Command 20h followed by a second 20h starts an erase. `busy` is high for `ERASE_CYC` cycles, and at the end every byte is FFh. If 20h is followed by any other code, no erase occurs and the block returns to array read.
- R8: Command A0h latches its own address, and reads then return the byte at that address. An A0h written while an erase is still running stops the erase and leaves the contents unchanged.
- R9: An operation that no verify interrupts ends when its count expires and `busy` falls. Until the next command, reads return 00h.
- R10: Two FFh writes in a row return the block to array read. After a single FFh, reads return 00h. Any command written while an operation runs stops it with no effect on the array.
- R11: An undefined command code, for example 55h, returns the block to array-read mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hv_en | input | 1 | High-voltage enable; low makes the block read-only |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | AW | Byte address |
| d | input | 8 | Write data / command code |
| q | output | 8 | Read data |
| q_oe | output | 1 | Output drive enable (low stands for high impedance) |
| busy | output | 1 | Program or erase timer running |

## Verification
A command takes effect at the first clock edge that sees the rising write strobe. The bench lowers the strobe on one falling clock edge and raises it on the next, so the command has acted by the falling edge after that. Read data is registered once. The bench therefore applies the read strobes on a falling edge and samples `q` on the next one. `busy` rises at the edge that executes the start write, and it stays high for exactly the programmed count. The bench counts the falling-edge samples in which `busy` is high and compares that count with the parameter. Early-stop checks place the verify write so that it executes while the timer is still running.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [3:0] {
    M_READ, M_ID, M_ERS_SETUP, M_ERS_RUN, M_ERS_VFY,
    M_PRG_SETUP, M_PRG_RUN, M_PRG_VFY, M_RST_SETUP
  } mode_e;

  localparam logic [7:0] C_READ  = 8'h00;
  localparam logic [7:0] C_ID    = 8'h90;
  localparam logic [7:0] C_ERASE = 8'h20;
  localparam logic [7:0] C_EVFY  = 8'hA0;
  localparam logic [7:0] C_PROG  = 8'h40;
  localparam logic [7:0] C_PVFY  = 8'hC0;
  localparam logic [7:0] C_RESET = 8'hFF;
  localparam logic [7:0] ID_MFR  = 8'h20;
  localparam logic [7:0] ID_DEV  = 8'h07;

  function automatic mode_e decode_cmd(input logic [7:0] code);
    case (code)
      C_READ:  decode_cmd = M_READ;
      C_ID:    decode_cmd = M_ID;
      C_ERASE: decode_cmd = M_ERS_SETUP;
      C_EVFY:  decode_cmd = M_ERS_VFY;
      C_PROG:  decode_cmd = M_PRG_SETUP;
      C_PVFY:  decode_cmd = M_PRG_VFY;
      C_RESET: decode_cmd = M_RST_SETUP;
      default: decode_cmd = M_READ;
    endcase
  endfunction
endpackage

// File: rtl/flash_strobe_latch.sv
module flash_strobe_latch #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  output logic          wr_stb,
  output logic [AW-1:0] addr_lat
);
  logic wr_q;
  logic fall;

  assign fall   = wr_q & ~wr_n & ~cs_n;
  assign wr_stb = ~wr_q & wr_n & ~cs_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q     <= 1'b1;
      addr_lat <= '0;
    end else begin
      wr_q <= wr_n;
      if (fall) addr_lat <= addr;
    end
  end

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(addr_lat));
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic stop_req,
  input  logic start_prog,
  input  logic start_erase,
  output logic busy,
  output logic done_prog,
  output logic done_erase
);
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic          is_erase;
  logic          last;

  assign busy       = (cnt != '0);
  assign last       = (cnt == CW'(1)) && !kill;
  assign done_prog  = last && !is_erase;
  assign done_erase = last && is_erase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      is_erase <= 1'b0;
    end else if (kill) begin
      cnt <= '0;
    end else if (start_prog) begin
      cnt      <= CW'(PROG_CYC);
      is_erase <= 1'b0;
    end else if (start_erase) begin
      cnt      <= CW'(ERASE_CYC);
      is_erase <= 1'b1;
    end else if (stop_req) begin
      cnt <= '0;
    end else if (cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > CW'(1) && !kill && !stop_req) |=> busy);
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hv_en,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output mode_e         mode,
  output logic          start_prog,
  output logic          start_erase,
  output logic          stop_req,
  output logic [AW-1:0] prog_addr,
  output logic [7:0]    prog_data,
  output logic [AW-1:0] vfy_addr
);
  logic  cmd_wr;
  mode_e mode_nx;

  assign cmd_wr      = wr_stb && hv_en;
  assign stop_req    = cmd_wr;
  assign start_prog  = cmd_wr && (mode == M_PRG_SETUP);
  assign start_erase = cmd_wr && (mode == M_ERS_SETUP) && (wr_data == C_ERASE);

  always_comb begin
    mode_nx = mode;
    if (!hv_en) begin
      mode_nx = M_READ;
    end else if (cmd_wr) begin
      case (mode)
        M_ERS_SETUP: mode_nx = (wr_data == C_ERASE) ? M_ERS_RUN : M_READ;
        M_PRG_SETUP: mode_nx = M_PRG_RUN;
        M_RST_SETUP: mode_nx = (wr_data == C_RESET) ? M_READ : decode_cmd(wr_data);
        default:     mode_nx = decode_cmd(wr_data);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= M_READ;
      prog_addr <= '0;
      prog_data <= '0;
      vfy_addr  <= '0;
    end else begin
      mode <= mode_nx;
      if (start_prog) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
      if (mode_nx == M_ERS_VFY && cmd_wr && mode != M_PRG_SETUP)
        vfy_addr <= wr_addr;
    end
  end

  // R1
  ro_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hv_en |=> (mode == M_READ));
  // R7
  erase_from_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_erase |=> (mode == M_ERS_RUN));
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_en,
  input  logic [AW-1:0] prog_addr,
  input  logic [7:0]    prog_data,
  input  logic          erase_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  assign rd_data = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : 8'hFF;

  always_ff @(posedge clk) begin
    if (!rst_n || erase_en) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (prog_en && int'(prog_addr) < DEPTH) begin
      mem[prog_addr] <= mem[prog_addr] & prog_data;
    end
  end

  // R7
  erased_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en |=> (rd_data == 8'hFF));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int AW        = $clog2(DEPTH),
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hv_en,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    d,
  output logic [7:0]    q,
  output logic          q_oe,
  output logic          busy
);
  logic          wr_stb;
  logic [AW-1:0] addr_lat;
  mode_e         mode;
  logic          start_prog, start_erase, stop_req;
  logic          done_prog, done_erase;
  logic [AW-1:0] prog_addr, vfy_addr, rd_addr;
  logic [7:0]    prog_data, arr_q, rd_val;

  flash_strobe_latch #(.AW(AW)) u_latch (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
    .wr_stb(wr_stb), .addr_lat(addr_lat)
  );

  flash_cmd_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .hv_en(hv_en), .wr_stb(wr_stb),
    .wr_addr(addr_lat), .wr_data(d), .mode(mode),
    .start_prog(start_prog), .start_erase(start_erase), .stop_req(stop_req),
    .prog_addr(prog_addr), .prog_data(prog_data), .vfy_addr(vfy_addr)
  );

  flash_op_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .kill(!hv_en), .stop_req(stop_req),
    .start_prog(start_prog), .start_erase(start_erase), .busy(busy),
    .done_prog(done_prog), .done_erase(done_erase)
  );

  flash_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
    .clk(clk), .rst_n(rst_n), .prog_en(done_prog), .prog_addr(prog_addr),
    .prog_data(prog_data), .erase_en(done_erase), .rd_addr(rd_addr),
    .rd_data(arr_q)
  );

  always_comb begin
    case (mode)
      M_ERS_VFY: rd_addr = vfy_addr;
      M_PRG_VFY: rd_addr = prog_addr;
      default:   rd_addr = addr;
    endcase
    case (mode)
      M_READ, M_ERS_VFY, M_PRG_VFY: rd_val = arr_q;
      M_ID: rd_val = (addr == AW'(0)) ? ID_MFR :
                     (addr == AW'(1)) ? ID_DEV : 8'h00;
      default: rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q    <= 8'h00;
      q_oe <= 1'b0;
    end else begin
      q_oe <= !cs_n && !rd_n;
      q    <= (!cs_n && !rd_n) ? rd_val : 8'h00;
    end
  end

  // R2
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_oe |-> $past(!cs_n && !rd_n));
  // R4
  id_mfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_oe && $past(mode == M_ID && addr == AW'(0))) |-> (q == ID_MFR));
endmodule

// File: tb/tb_flash_cmd_ctrl.sv
module tb_flash_cmd_ctrl;
  localparam int DEPTH = 16;
  localparam int AW = 4;
  localparam int PC = 8;
  localparam int EC = 20;

  logic clk = 0, rst_n = 0, hv_en = 1, cs_n = 1, rd_n = 1, wr_n = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] d = '0;
  logic [7:0] q;
  logic q_oe, busy;
  int n_run = 0, n_fail = 0;

  flash_cmd_ctrl #(.DEPTH(DEPTH), .AW(AW), .PROG_CYC(PC), .ERASE_CYC(EC)) dut (
    .clk(clk), .rst_n(rst_n), .hv_en(hv_en), .cs_n(cs_n), .rd_n(rd_n),
    .wr_n(wr_n), .addr(addr), .d(d), .q(q), .q_oe(q_oe), .busy(busy)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr2(input logic [AW-1:0] a, input logic [AW-1:0] a2, input logic [7:0] v);
    @(negedge clk); cs_n = 0; addr = a; wr_n = 0;
    @(negedge clk); addr = a2; d = v; wr_n = 1;
    @(negedge clk); cs_n = 1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] v);
    wr2(a, a, v);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk); cs_n = 0; rd_n = 0; addr = a;
    @(negedge clk); v = q;
    rd_n = 1; cs_n = 1;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 busy after reset", busy, 0);
    chk("R2 q_oe idle", q_oe, 0);
    rd(4'd5, v);
    chk("R1 array FF after reset", v, 8'hFF);
    @(negedge clk); cs_n = 0; rd_n = 0;
    @(negedge clk); chk("R2 q_oe when read", q_oe, 1);
    rd_n = 1;
    @(negedge clk); chk("R2 q_oe off with rd_n high", q_oe, 0);
    cs_n = 1;
  endtask

  task automatic t_ident;
    logic [7:0] v;
    wr(0, 8'h90);
    rd(0, v); chk("R4 mfr code", v, 8'h20);
    rd(1, v); chk("R4 dev code", v, 8'h07);
    rd(2, v); chk("R4 other addr", v, 8'h00);
    wr(0, 8'h00);
  endtask

  task automatic t_program;
    logic [7:0] v; int n;
    wr(0, 8'h40); wr(3, 8'h5A);
    busy_len(n); chk("R5 program busy length", n, PC);
    wr(0, 8'hC0); rd(0, v); chk("R6 verify 5A", v, 8'h5A);
    wr(0, 8'h40); wr(3, 8'h0F); busy_len(n);
    wr(0, 8'h00); rd(3, v); chk("R5 AND of old and new", v, 8'h0A);
    wr(0, 8'h40); wr(5, 8'h00);
    chk("R6 busy before early stop", busy, 1);
    wr(0, 8'hC0); chk("R6 busy cleared by C0", busy, 0);
    rd(9, v); chk("R6 early stop byte unchanged", v, 8'hFF);
  endtask

  task automatic t_addr_latch;
    logic [7:0] v; int n;
    wr(0, 8'h40); wr2(4, 6, 8'h11); busy_len(n);
    wr(0, 8'h00);
    rd(4, v); chk("R3 falling-edge address used", v, 8'h11);
    rd(6, v); chk("R3 late address ignored", v, 8'hFF);
  endtask

  task automatic t_erase;
    logic [7:0] v; int n;
    wr(0, 8'h20); wr(0, 8'h00);
    chk("R7 no erase after bad second code", busy, 0);
    rd(3, v); chk("R7 setup abort keeps data, reads array", v, 8'h0A);
    wr(0, 8'h20); wr(0, 8'h20);
    chk("R8 busy before early stop", busy, 1);
    wr(3, 8'hA0); rd(0, v); chk("R8 early A0 leaves data", v, 8'h0A);
    wr(0, 8'h20); wr(0, 8'h20);
    busy_len(n); chk("R7 erase busy length", n, EC);
    wr(3, 8'hA0); rd(0, v); chk("R8 erase verify FF", v, 8'hFF);
    wr(0, 8'h00); rd(4, v); chk("R7 all bytes FF", v, 8'hFF);
  endtask

  task automatic t_stop_timer;
    logic [7:0] v; int n;
    wr(0, 8'h40); wr(9, 8'h33);
    busy_len(n); chk("R9 timer ends op", busy, 0);
    rd(9, v); chk("R9 idle read 00", v, 8'h00);
    wr(0, 8'hC0); rd(0, v); chk("R9 completed byte", v, 8'h33);
  endtask

  task automatic t_reset_cmd;
    logic [7:0] v;
    wr(0, 8'hFF); rd(9, v); chk("R10 single FF reads 00", v, 8'h00);
    wr(0, 8'hFF); rd(9, v); chk("R10 double FF read array", v, 8'h33);
    wr(0, 8'h40); wr(10, 8'h00); wr(0, 8'hFF);
    chk("R10 FF stops program", busy, 0);
    wr(0, 8'hFF); rd(10, v); chk("R10 aborted byte unchanged", v, 8'hFF);
    wr(0, 8'h90); wr(0, 8'h55); rd(9, v);
    chk("R11 undefined code to read", v, 8'h33);
  endtask

  task automatic t_read_only;
    logic [7:0] v;
    wr(0, 8'h90);
    hv_en = 0;
    rd(9, v); chk("R1 hv low forces read", v, 8'h33);
    wr(0, 8'h40); wr(2, 8'h00);
    chk("R1 hv low no busy", busy, 0);
    rd(2, v); chk("R1 hv low write ignored", v, 8'hFF);
    hv_en = 1;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset; t_ident; t_program; t_addr_latch;
        t_erase; t_stop_timer; t_reset_cmd; t_read_only;
      end
      begin
        repeat (20000) @(negedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule